// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is a single timer channel that measures input timing. A 16-bit up-counter advances on ticks drawn from either a divided system clock or one of three external clock lines. The tick may come from the rising or the falling edge of that clock, and it can be gated by another external line. Chosen edges of input A copy the counter into two capture registers, A first and then B. A software command, a selected edge of input A or B, or a match against a compare register raises a trigger. A trigger clears the counter on the next tick and re-arms the capture sequence.

Software uses a word-addressed register port with a write strobe, a read strobe and a combinational read bus. Reading the status register clears its event flags. Reading a capture register marks it as consumed, which is what the load-overrun flag tests. The interrupt line is the OR of the event flags allowed by a mask.

Two state machines carry the control. The clock machine has the states CLK_OFF, CLK_RUN and CLK_FROZEN. CLK_OFF goes to CLK_RUN on an enable command. CLK_RUN goes to CLK_OFF on a disable command or on a B load with disable-on-B set. CLK_RUN goes to CLK_FROZEN on a B load with stop-on-B set. CLK_FROZEN goes to CLK_OFF on a disable command and to CLK_RUN on any trigger. The capture machine has the states CAP_WAIT_A and CAP_WAIT_B. CAP_WAIT_A goes to CAP_WAIT_B on an A load. CAP_WAIT_B goes to CAP_WAIT_A on a B load. Any trigger forces CAP_WAIT_A.

Top module: `tmr_capture_chan`

## Requirements
- R1: After reset the counter reads 0, the status reads 0 and irq is low. The word addresses are: 0 command (write), 1 mode, 2 counter, 3 capture A, 4 capture B, 5 compare value (reset value all ones), 6 status, 7 mask set, 8 mask clear, 9 mask read.
- R2: A command write with bit 0 set enables the counting clock, and one with bit 1 set disables it; when both are set, disable wins. Status bit 16 reads 1 while the clock is enabled. While the clock is disabled, ticks leave the counter unchanged.
- R3: Mode bits 2:0 select the tick source. Codes 0 to 4 divide the system clock by 2, 8, 32, 128 or 1024, and codes 5 to 7 take external clock 0 to 2. The counter adds one per tick. Mode bit 3 set makes the falling edge of the source the tick instead of the rising edge.
- R4: Mode bits 5:4, when nonzero, AND the selected source with external clock (value-1). While that gating line is low, the counter does not advance.
- R5: Mode bits 17:16 choose the input-A edge that loads capture A, and bits 19:18 the edge that loads capture B (1 rising, 2 falling, 3 either, 0 never). B loads only after A has loaded since the last trigger or the last B load. Loads set status bit 5 (A) and bit 6 (B).
- R6: Loading a capture register whose previous value has not been read sets status bit 1 (load overrun).
- R7: On a B load, mode bit 6 freezes counting until the next trigger, with status bit 16 still 1. Mode bit 7 disables the clock instead, and status bit 16 then reads 0.
- R8: A trigger comes from a command write with bit 2 set or from an external edge. The edge is selected by mode bits 9:8 (1 rising, 2 falling, 3 either) on input A when mode bit 10 is 1, or on input B when it is 0. An external trigger sets status bit 7. After any trigger, the next tick loads 0 and counting continues from there.
- R9: When the counter steps onto the compare value, status bit 4 is set. If mode bit 14 is also set, this match acts as a trigger.
- R10: A tick at the all-ones count wraps the counter to 0 and sets status bit 0.
- R11: Reading the status clears bits 7:0. Bits 17 and 18 show the present levels of inputs A and B.
- R12: irq is high while any status bit 7:0 is set whose bit in the 8-bit mask is also set. A write to address 7 sets mask bits, and a write to address 8 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| ext_clk | input | 3 | External clock / gating lines 0 to 2 |
| in_a | input | 1 | Capture and trigger input A |
| in_b | input | 1 | Trigger input B |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write or an input-A/B edge that is present at a clock edge takes effect at that edge: capture values, flags and state are visible on the next read. An external clock change takes one more edge to become a tick, and the counter moves on the edge after that. The bench therefore holds each external pulse level and each input level for three clock cycles before the next step. It drives all inputs at the falling edge and samples rdata and irq 1 ns later, so every result is read only after the edge that produced it. The divided-clock checks allow a window of a few counts, because the phase of the free-running prescaler is not fixed.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CAPA  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CAPB  = 4'd4;
    localparam logic [ADDR_W-1:0] A_RCMP  = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
    localparam logic [ADDR_W-1:0] A_IDIS  = 4'd8;
    localparam logic [ADDR_W-1:0] A_IMASK = 4'd9;

    typedef enum logic [1:0] {CLK_OFF, CLK_RUN, CLK_FROZEN} clk_state_t;
    typedef enum logic {CAP_WAIT_A, CAP_WAIT_B} cap_state_t;

    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction
endpackage

// File: rtl/tcc_tick_gen.sv
`timescale 1ns/1ps
module tcc_tick_gen #(
    parameter int PRESC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic       fall_edge,
    input  logic [1:0] gate_sel,
    input  logic [2:0] ext_clk,
    output logic       tick
);
    logic [PRESC_W-1:0] presc;
    logic [2:0]         ext_q;
    logic               lvl_q;
    logic               src_lvl;
    logic               gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            ext_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            presc <= presc + 1'b1;
            ext_q <= ext_clk;
            lvl_q <= gated;
        end
    end

    // divide by 2^(k+1) is prescaler bit k
    always_comb begin
        unique case (src_sel)
            3'd0:    src_lvl = presc[0];
            3'd1:    src_lvl = presc[2];
            3'd2:    src_lvl = presc[4];
            3'd3:    src_lvl = presc[6];
            3'd4:    src_lvl = presc[9];
            3'd5:    src_lvl = ext_q[0];
            3'd6:    src_lvl = ext_q[1];
            default: src_lvl = ext_q[2];
        endcase
        unique case (gate_sel)
            2'd0:    gated = src_lvl;
            2'd1:    gated = src_lvl & ext_q[0];
            2'd2:    gated = src_lvl & ext_q[1];
            default: gated = src_lvl & ext_q[2];
        endcase
    end

    assign tick = fall_edge ? (lvl_q & ~gated) : (gated & ~lvl_q);

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tcc_edge_det.sv
`timescale 1ns/1ps
module tcc_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/tmr_capture_chan.sv
`timescale 1ns/1ps
module tmr_capture_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [2:0]  ext_clk,
    input  logic        in_a,
    input  logic        in_b,
    output logic        irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int EV_W = 8;

    // register strobes
    logic wr_cmd, wr_mode, wr_rcmp, wr_ien, wr_idis, rd_stat, rd_capa, rd_capb;
    assign wr_cmd  = wr_en && addr == A_CMD;
    assign wr_mode = wr_en && addr == A_MODE;
    assign wr_rcmp = wr_en && addr == A_RCMP;
    assign wr_ien  = wr_en && addr == A_IEN;
    assign wr_idis = wr_en && addr == A_IDIS;
    assign rd_stat = rd_en && addr == A_STAT;
    assign rd_capa = rd_en && addr == A_CAPA;
    assign rd_capb = rd_en && addr == A_CAPB;

    logic cmd_en, cmd_dis, cmd_trg;
    assign cmd_en  = wr_cmd & wdata[0];
    assign cmd_dis = wr_cmd & wdata[1];
    assign cmd_trg = wr_cmd & wdata[2];

    // mode word and fields
    logic [31:0] mode;
    logic [2:0]  m_src;
    logic        m_fall, m_bstop, m_bdis, m_tsrc_a, m_rctrg;
    logic [1:0]  m_gate, m_tedge, m_lda, m_ldb;
    assign m_src    = mode[2:0];
    assign m_fall   = mode[3];
    assign m_gate   = mode[5:4];
    assign m_bstop  = mode[6];
    assign m_bdis   = mode[7];
    assign m_tedge  = mode[9:8];
    assign m_tsrc_a = mode[10];
    assign m_rctrg  = mode[14];
    assign m_lda    = mode[17:16];
    assign m_ldb    = mode[19:18];

    // submodules
    logic       tick;
    logic [1:0] rise, fall;

    tcc_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(m_src), .fall_edge(m_fall),
        .gate_sel(m_gate), .ext_clk(ext_clk), .tick(tick)
    );

    tcc_edge_det #(.W(2)) u_edges (
        .clk(clk), .rst_n(rst_n), .sig({in_b, in_a}), .rise(rise), .fall(fall)
    );

    // state registers
    clk_state_t clk_st, clk_nx;
    cap_state_t cap_st, cap_nx;

    logic [CNT_W-1:0] cnt, cnt_nxt, cap_a, cap_b, rcmp;
    logic             trig_pend, a_full, b_full;
    logic [EV_W-1:0]  ev, ev_set, imask;

    logic clock_on, running, count_tick, load_a, load_b;
    logic ext_trig, rc_hit, ovf, lovr, trig_any;

    // state-derived outputs
    always_comb begin
        clock_on = 1'b0;
        running  = 1'b0;
        unique case (clk_st)
            CLK_OFF:    begin clock_on = 1'b0; running = 1'b0; end
            CLK_RUN:    begin clock_on = 1'b1; running = 1'b1; end
            CLK_FROZEN: begin clock_on = 1'b1; running = 1'b0; end
            default:    begin clock_on = 1'b0; running = 1'b0; end
        endcase
        load_a = 1'b0;
        load_b = 1'b0;
        unique case (cap_st)
            CAP_WAIT_A: load_a = clock_on && edge_hit(m_lda, rise[0], fall[0]);
            CAP_WAIT_B: load_b = clock_on && edge_hit(m_ldb, rise[0], fall[0]);
            default: ;
        endcase
    end

    assign count_tick = tick && running;
    assign cnt_nxt    = trig_pend ? '0 : cnt + 1'b1;
    assign rc_hit     = count_tick && (cnt_nxt == rcmp);
    assign ovf        = count_tick && !trig_pend && (cnt == CNT_MAX);
    assign ext_trig   = m_tsrc_a ? edge_hit(m_tedge, rise[0], fall[0])
                                 : edge_hit(m_tedge, rise[1], fall[1]);
    assign trig_any   = cmd_trg | ext_trig | (rc_hit & m_rctrg);
    assign lovr       = (load_a & a_full) | (load_b & b_full);
    assign ev_set     = {ext_trig, load_b, load_a, rc_hit, 2'b00, lovr, ovf};

    // clock state machine
    always_comb begin
        clk_nx = clk_st;
        unique case (clk_st)
            CLK_OFF:    if (cmd_en && !cmd_dis) clk_nx = CLK_RUN;
            CLK_RUN: begin
                if (cmd_dis)                  clk_nx = CLK_OFF;
                else if (load_b && m_bdis)    clk_nx = CLK_OFF;
                else if (load_b && m_bstop)   clk_nx = CLK_FROZEN;
            end
            CLK_FROZEN: begin
                if (cmd_dis)       clk_nx = CLK_OFF;
                else if (trig_any) clk_nx = CLK_RUN;
            end
            default:    clk_nx = CLK_OFF;
        endcase
    end

    // capture state machine
    always_comb begin
        cap_nx = cap_st;
        if (trig_any) cap_nx = CAP_WAIT_A;
        else begin
            unique case (cap_st)
                CAP_WAIT_A: if (load_a) cap_nx = CAP_WAIT_B;
                CAP_WAIT_B: if (load_b) cap_nx = CAP_WAIT_A;
                default:    cap_nx = CAP_WAIT_A;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_st <= CLK_OFF;
            cap_st <= CAP_WAIT_A;
        end else begin
            clk_st <= clk_nx;
            cap_st <= cap_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode      <= '0;
            rcmp      <= CNT_MAX;
            cnt       <= '0;
            trig_pend <= 1'b0;
            cap_a     <= '0;
            cap_b     <= '0;
            a_full    <= 1'b0;
            b_full    <= 1'b0;
            ev        <= '0;
            imask     <= '0;
        end else begin
            if (wr_mode) mode <= wdata;
            if (wr_rcmp) rcmp <= wdata[CNT_W-1:0];
            if (count_tick) cnt <= cnt_nxt;
            if (trig_any)        trig_pend <= 1'b1;
            else if (count_tick) trig_pend <= 1'b0;
            if (load_a) cap_a <= cnt;
            if (load_b) cap_b <= cnt;
            if (load_a)       a_full <= 1'b1;
            else if (rd_capa) a_full <= 1'b0;
            if (load_b)       b_full <= 1'b1;
            else if (rd_capb) b_full <= 1'b0;
            ev <= (rd_stat ? '0 : ev) | ev_set;
            if (wr_ien)       imask <= imask | wdata[EV_W-1:0];
            else if (wr_idis) imask <= imask & ~wdata[EV_W-1:0];
        end
    end

    assign irq = |(ev & imask);

    // read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE:  rdata = mode;
            A_CNT:   rdata[CNT_W-1:0] = cnt;
            A_CAPA:  rdata[CNT_W-1:0] = cap_a;
            A_CAPB:  rdata[CNT_W-1:0] = cap_b;
            A_RCMP:  rdata[CNT_W-1:0] = rcmp;
            A_STAT:  rdata = {13'b0, in_b, in_a, clock_on, 8'b0, ev};
            A_IMASK: rdata[EV_W-1:0] = imask;
            default: rdata = '0;
        endcase
    end

    // assertions
    assert_cnt_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cnt));
    assert_disable_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> clk_st == CLK_OFF);
    assert_b_waits_for_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_st == CAP_WAIT_A |=> $stable(cap_b));
    assert_bstop_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_b && m_bstop && !m_bdis && !cmd_dis && clk_st == CLK_RUN) |=> clk_st == CLK_FROZEN);
    assert_trig_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && trig_pend) |=> cnt == '0);
    assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0 && ev[0]));
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && ev_set == '0) |=> ev == '0);
    assert_mask_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idis && &wdata[EV_W-1:0]) |=> !irq);
endmodule

// File: tb/test_tmr_capture_chan.sv
`timescale 1ns/1ps
module test_tmr_capture_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  ext_clk = '0;
    logic        in_a = 1'b0, in_b = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_capture_chan i_tmr_capture_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .in_a(in_a),
        .in_b(in_b), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk[0] = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk[0] = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic set_a(input logic v);
        @(negedge clk); in_a = v; repeat (3) @(negedge clk);
    endtask

    task automatic set_b(input logic v);
        @(negedge clk); in_b = v; repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_mode(input int src, input int fe, input int gate,
        input int bstop, input int bdis, input int tedge, input int tsrca,
        input int rctrg, input int lda, input int ldb);
        return 32'(src) | 32'(fe) << 3 | 32'(gate) << 4 | 32'(bstop) << 6 |
               32'(bdis) << 7 | 32'(tedge) << 8 | 32'(tsrca) << 10 |
               32'(rctrg) << 14 | 32'(lda) << 16 | 32'(ldb) << 18;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(2, v); chk("R1 counter after reset", v, 0);
        rd(6, v); chk("R1 status after reset", v, 0);
        chk("R1 irq after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(1, mk_mode(5,0,0,0,0,0,0,0,0,0));
        wr(0, 1);
        pulses(5);
        rd(2, v); chk("R3 five external ticks", v, 5);
        rd(6, v); chk("R2 clock enabled bit16", v & 32'h10000, 32'h10000);
        wr(0, 2);
        pulses(2);
        rd(2, v); chk("R2 disabled clock holds", v, 5);
        wr(0, 3);
        rd(6, v); chk("R2 disable wins over enable", v & 32'h10000, 0);
    endtask

    task automatic t_invert;
        logic [31:0] v;
        wr(1, mk_mode(5,1,0,0,0,0,0,0,0,0));
        wr(0, 5);
        pulses(1);
        @(negedge clk); ext_clk[0] = 1'b1; repeat (3) @(negedge clk);
        rd(2, v); chk("R3 falling mode ignores rise", v, 0);
        @(negedge clk); ext_clk[0] = 1'b0; repeat (3) @(negedge clk);
        rd(2, v); chk("R3 falling mode counts fall", v, 1);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        wr(1, mk_mode(5,0,2,0,0,0,0,0,0,0));
        wr(0, 5);
        @(negedge clk); ext_clk[1] = 1'b1;
        pulses(2);
        @(negedge clk); ext_clk[1] = 1'b0;
        pulses(2);
        rd(2, v); chk("R4 gate low blocks ticks", v, 1);
        @(negedge clk); ext_clk[1] = 1'b1;
        pulses(1);
        rd(2, v); chk("R4 gate high passes ticks", v, 2);
        @(negedge clk); ext_clk[1] = 1'b0;
    endtask

    task automatic t_capture;
        logic [31:0] v;
        wr(1, mk_mode(5,0,0,0,0,0,0,0,1,2));
        rd(6, v);
        wr(0, 5);
        pulses(4);
        set_a(1);
        pulses(2);
        set_a(0);
        rd(3, v); chk("R5 capture A on rise", v, 3);
        rd(4, v); chk("R5 capture B on fall", v, 5);
        rd(6, v); chk("R5 load flags, no overrun", v, 32'h10060);
    endtask

    task automatic t_order_overrun;
        logic [31:0] v;
        set_a(1);
        wr(0, 4);
        set_a(0);
        rd(4, v); chk("R5 B not loaded before A", v, 5);
        rd(6, v); chk("R5 B flag stays clear", v & 32'h40, 0);
        set_a(1);
        rd(6, v); chk("R6 overrun on unread A", v & 32'h2, 32'h2);
        rd(6, v); chk("R11 status read clears events", v & 32'hFF, 0);
    endtask

    task automatic t_stop_dis;
        logic [31:0] v;
        wr(1, mk_mode(5,0,0,1,0,0,0,0,1,2));
        wr(0, 5);
        pulses(3);
        set_a(0); set_a(1); set_a(0);
        pulses(2);
        rd(2, v); chk("R7 frozen after B load", v, 2);
        rd(6, v); chk("R7 frozen keeps enabled bit", v & 32'h10000, 32'h10000);
        wr(0, 4);
        pulses(2);
        rd(2, v); chk("R7 trigger resumes from zero", v, 1);
        wr(1, mk_mode(5,0,0,0,1,0,0,0,1,2));
        wr(0, 4);
        set_a(1); set_a(0);
        rd(6, v); chk("R7 B load disables clock", v & 32'h10000, 0);
        pulses(1);
        rd(2, v); chk("R7 disabled after B holds", v, 1);
    endtask

    task automatic t_ext_trig;
        logic [31:0] v;
        wr(1, mk_mode(5,0,0,0,0,1,0,0,0,0));
        wr(0, 1);
        rd(6, v);
        set_b(1);
        pulses(3);
        rd(2, v); chk("R8 input B rising trigger", v, 2);
        rd(6, v); chk("R8 external trigger flag", v & 32'h80, 32'h80);
    endtask

    task automatic t_rc;
        logic [31:0] v;
        wr(5, 4);
        wr(1, mk_mode(5,0,0,0,0,0,0,1,0,0));
        wr(0, 5);
        pulses(8);
        rd(2, v); chk("R9 compare restarts counter", v, 2);
        rd(6, v); chk("R9 compare flag", v & 32'h10, 32'h10);
        wr(5, 32'hFFFF);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(1, mk_mode(5,0,0,0,0,0,0,0,1,2));
        wr(0, 5);
        rd(6, v);
        wr(7, 32'h20);
        rd(9, v); chk("R12 mask set", v, 32'h20);
        set_a(1);
        #1 chk("R12 irq on enabled A load", {31'b0, irq}, 1);
        rd(6, v);
        #1 chk("R12 irq drops after read", {31'b0, irq}, 0);
        wr(8, 32'hFF);
        set_a(0); set_a(1);
        #1 chk("R12 masked A load gives no irq", {31'b0, irq}, 0);
    endtask

    task automatic t_levels;
        logic [31:0] v;
        set_b(0);
        rd(6, v); chk("R11 levels A=1 B=0", v & 32'h60000, 32'h20000);
        set_a(0); set_b(1);
        rd(6, v); chk("R11 levels A=0 B=1", v & 32'h60000, 32'h40000);
    endtask

    task automatic t_div;
        logic [31:0] v;
        wr(1, mk_mode(1,0,0,0,0,0,0,0,0,0));
        wr(0, 5);
        repeat (400) @(negedge clk);
        rd(2, v);
        chk("R3 divide-by-8 rate", {31'b0, (v >= 47 && v <= 52)}, 1);
    endtask

    task automatic t_ovf;
        logic [31:0] v;
        wr(0, 2);
        wr(1, mk_mode(0,0,0,0,0,0,0,0,0,0));
        rd(6, v);
        wr(0, 5);
        repeat (131200) @(negedge clk);
        rd(6, v); chk("R10 overflow flag", v & 32'h1, 1);
        rd(2, v); chk("R10 counter wrapped", {31'b0, v < 100}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_invert();
        t_gate();
        t_capture();
        t_order_overrun();
        t_stop_dis();
        t_ext_trig();
        t_rc();
        t_irq();
        t_levels();
        t_div();
        t_ovf();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule